// File: doc/BRIEF.md
# Double-Buffered Display Line Latch with Dot-Inversion Polarity

This block gathers one display line of 6-bit gray codes for a column driver. Each clock it can take one row of six samples, which is two pixels of red, green and blue. It stores that row into one group of a line-wide input buffer. The group is chosen by a slot number from an outside pointer and by a shift-direction bit. Each half of the six-sample row can be complemented bit by bit as it is captured. Sending complemented data cuts the switching on the input bus, and the capture undoes it.

A separate load strobe arrives without a fixed timing relation to the clock. Inside the block it is synchronised and edge-detected. The detected edge copies the whole input buffer into an output buffer in a single clock. On the same edge the block latches a polarity bit, which marks each channel as driven from the positive or the negative reference range. Neighbouring channels always take opposite ranges.

The next line can be written into the input buffer while the present line is shown. A load that comes before the line is full still transfers everything the buffer holds. With default parameters the block has 420 channels in 70 groups of six.

Top module: `dot_line_latch`

## Requirements
- R1: After the synchronous active-high reset `rst`, every channel code on `code_out` is zero and the latched polarity is 0, so `pos_out[i]` is 1 exactly when the index `i` is even (channel number `i+1` odd).
- R2: `din` carries sample `j` (0..5) at bits `[6j+5:6j]`, with bit `6j+5` as its MSB. Sample `j` of a row written into group `g` ends up in channel number `6g+j+1`, whose code is at `code_out[6n-1:6n-6]` for channel number `n`.
- R3: When `inv_lo` is 1, samples 0 to 2 are stored bitwise complemented (00 becomes 3F, 07 becomes 38, 15 becomes 2A). When `inv_hi` is 1, samples 3 to 5 are stored complemented. Both controls are sampled on the same rising edge as the data.
- R4: With `shift_fwd` = 1, slot `k` writes group `k` (channels `6k+1` to `6k+6`). With `shift_fwd` = 0, slot `k` writes group `69-k`, so slot 0 fills channels 415 to 420 and slot 69 fills channels 1 to 6.
- R5: `code_out` and `pos_out` change only on a transfer. Writes into the input buffer are not visible until then.
- R6: Suppose `ld` is sampled 1 at rising edge E0 and was sampled 0 at the edge before E0. The transfer then happens at edge E2, two edges after E0. After E2, `code_out` shows the input buffer including the writes sampled at edges up to E1. A write sampled at E2 is not included.
- R7: A transfer copies every group. Groups not written since an earlier write keep their earlier input-buffer contents, so a partly filled line shows new and old groups together.
- R8: `pol` is sampled at the same edge E0 as `ld`. After the transfer, `pos_out[i]` = 1 (positive range) when `pol` = 1 and channel number `i+1` is even, or when `pol` = 0 and `i+1` is odd. Otherwise `pos_out[i]` = 0 (negative range).
- R9: Each rising edge of `ld` causes exactly one transfer. Keeping `ld` high causes no further transfer, so writes made after the first transfer stay hidden.
- R10: A row is ignored when `wr_en` is 0 or when `wr_slot` is 70 or more. The input buffer is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Row write enable |
| wr_slot | input | 7 | Slot number from the outside pointer |
| shift_fwd | input | 1 | 1 = slot k to group k, 0 = slot k to group 69-k |
| inv_lo | input | 1 | Complement samples 0 to 2 of the row |
| inv_hi | input | 1 | Complement samples 3 to 5 of the row |
| din | input | 36 | Six 6-bit samples |
| ld | input | 1 | Load strobe, asynchronous to clk |
| pol | input | 1 | Polarity request, latched with the load |
| code_out | output | 2520 | 420 channel codes, channel n at bits [6n-1:6n-6] |
| pos_out | output | 420 | Per-channel flag, 1 = positive reference range |

## Verification
The assertions on transfer timing assume the following about the inputs. Reset lasts at least three clocks. `ld` is low during reset, and once it rises it stays high for at least one sampling edge. Given that, any internal transfer pulse can be traced back to a low-to-high step of `ld` two and three edges earlier. The stimulus drives every input on the falling edge. It holds reset for four edges with `ld` low, and it raises `ld` only from a low level of at least one full clock. The polarity is kept steady across each load, so the polarity latch never samples a changing value.

// File: rtl/dll_pkg.sv
package dll_pkg;

  // idx is zero-based; the channel number is idx+1.
  // pol_q = 1 puts even-numbered channels on the positive range.
  function automatic logic is_positive(input int unsigned idx, input logic pol_q);
    logic odd_index;
    odd_index = idx[0];
    return pol_q ? odd_index : ~odd_index;
  endfunction

endpackage

// File: rtl/dll_capture.sv
module dll_capture #(
  parameter int SAMPLES = 6,
  parameter int BITS    = 6,
  parameter int GROUPS  = 70,
  parameter int SLOT_W  = 7,
  localparam int GW     = SAMPLES * BITS,
  localparam int LINE_W = GW * GROUPS,
  localparam int HALF   = SAMPLES / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              shift_fwd,
  input  logic              inv_lo,
  input  logic              inv_hi,
  input  logic [GW-1:0]     din,
  output logic [LINE_W-1:0] line_q
);

  logic [GW-1:0]     row_fixed;
  logic [SLOT_W-1:0] grp;
  logic              hit;
  logic [GW-1:0]     mem [GROUPS];

  // per-half complement of the incoming row
  for (genvar j = 0; j < SAMPLES; j++) begin : g_samp
    if (j < HALF) begin : g_lo
      assign row_fixed[j*BITS +: BITS] = din[j*BITS +: BITS] ^ {BITS{inv_lo}};
    end else begin : g_hi
      assign row_fixed[j*BITS +: BITS] = din[j*BITS +: BITS] ^ {BITS{inv_hi}};
    end
  end

  // slot-to-group mapping depends on shift direction
  always_comb begin
    hit = wr_en && (int'(wr_slot) < GROUPS);
    grp = shift_fwd ? wr_slot : (SLOT_W'(GROUPS - 1) - wr_slot);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < GROUPS; g++) mem[g] <= '0;
    end else if (hit) begin
      mem[grp] <= row_fixed;
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_flat
    assign line_q[g*GW +: GW] = mem[g];
  end

endmodule

// File: rtl/dll_strobe_sync.sv
module dll_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ld,
  input  logic pol,
  output logic xfer,
  output logic pol_sync
);

  logic [STAGES-1:0] ld_pipe;
  logic [STAGES-1:0] pol_pipe;
  logic              ld_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_pipe  <= '0;
      pol_pipe <= '0;
      ld_prev  <= 1'b0;
    end else begin
      ld_pipe  <= {ld_pipe[STAGES-2:0], ld};
      pol_pipe <= {pol_pipe[STAGES-2:0], pol};
      ld_prev  <= ld_pipe[STAGES-1];
    end
  end

  assign xfer     = ld_pipe[STAGES-1] & ~ld_prev;
  assign pol_sync = pol_pipe[STAGES-1];

endmodule

// File: rtl/dll_hold.sv
module dll_hold #(
  parameter int CHANNELS = 420,
  parameter int BITS     = 6,
  localparam int LINE_W  = CHANNELS * BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                xfer,
  input  logic                pol_sync,
  input  logic [LINE_W-1:0]   line_in,
  output logic [LINE_W-1:0]   code_out,
  output logic [CHANNELS-1:0] pos_out
);

  logic [CHANNELS-1:0] pos_next;
  logic [CHANNELS-1:0] pos_rst;

  for (genvar i = 0; i < CHANNELS; i++) begin : g_pos
    assign pos_next[i] = dll_pkg::is_positive(i, pol_sync);
    assign pos_rst[i]  = dll_pkg::is_positive(i, 1'b0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_out <= '0;
      pos_out  <= pos_rst;
    end else if (xfer) begin
      code_out <= line_in;
      pos_out  <= pos_next;
    end
  end

endmodule

// File: rtl/dot_line_latch.sv
module dot_line_latch #(
  parameter int CHANNELS    = 420,
  parameter int SAMPLES     = 6,
  parameter int BITS        = 6,
  parameter int SYNC_STAGES = 2,
  localparam int GROUPS     = CHANNELS / SAMPLES,
  localparam int SLOT_W     = $clog2(GROUPS),
  localparam int GW         = SAMPLES * BITS,
  localparam int LINE_W     = CHANNELS * BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [SLOT_W-1:0]   wr_slot,
  input  logic                shift_fwd,
  input  logic                inv_lo,
  input  logic                inv_hi,
  input  logic [GW-1:0]       din,
  input  logic                ld,
  input  logic                pol,
  output logic [LINE_W-1:0]   code_out,
  output logic [CHANNELS-1:0] pos_out
);

  logic [LINE_W-1:0] line_q;
  logic              xfer;
  logic              pol_sync;

  dll_capture #(
    .SAMPLES(SAMPLES), .BITS(BITS), .GROUPS(GROUPS), .SLOT_W(SLOT_W)
  ) u_capture (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot),
    .shift_fwd(shift_fwd), .inv_lo(inv_lo), .inv_hi(inv_hi),
    .din(din), .line_q(line_q)
  );

  dll_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ld(ld), .pol(pol),
    .xfer(xfer), .pol_sync(pol_sync)
  );

  dll_hold #(.CHANNELS(CHANNELS), .BITS(BITS)) u_hold (
    .clk(clk), .rst(rst), .xfer(xfer), .pol_sync(pol_sync),
    .line_in(line_q), .code_out(code_out), .pos_out(pos_out)
  );

endmodule

// File: rtl/dll_checker.sv
module dll_checker #(
  parameter int CHANNELS = 420,
  parameter int BITS     = 6
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       ld,
  input logic                       xfer,
  input logic [CHANNELS*BITS-1:0]   code_out,
  input logic [CHANNELS-1:0]        pos_out
);

  // R1: reset clears codes, polarity 0 makes channel 1 positive
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (code_out == '0 && pos_out[0] && !pos_out[1]));

  // R5: outputs move only after a transfer pulse
  a_r5_codes_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(xfer) |-> $stable(code_out));

  a_r5_pos_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(xfer) |-> $stable(pos_out));

  // R8: neighbouring channels always on opposite ranges
  a_r8_alternate: assert property (@(posedge clk) disable iff (rst)
    pos_out[0] != pos_out[1]);

  // R9: one transfer per strobe edge
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    xfer |=> !xfer);

  // R6: a transfer follows a low-to-high strobe step two edges earlier
  a_r6_strobe_origin: assert property (@(posedge clk) disable iff (rst)
    xfer |-> ($past(ld, 2) && !$past(ld, 3)));

endmodule

bind dot_line_latch dll_checker #(.CHANNELS(CHANNELS), .BITS(BITS)) u_chk (
  .clk(clk), .rst(rst), .ld(ld), .xfer(xfer),
  .code_out(code_out), .pos_out(pos_out)
);

// File: tb/tb_dot_line_latch.sv
module tb_dot_line_latch;
  localparam int CH = 420;
  localparam int SPC = 6;
  localparam int BW = 6;
  localparam int GR = 70;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, wr_en = 1'b0, shift_fwd = 1'b1, inv_lo = 1'b0, inv_hi = 1'b0;
  logic [6:0] wr_slot = '0;
  logic [35:0] din = '0;
  logic ld = 1'b0, pol = 1'b0;
  logic [CH*BW-1:0] code_out;
  logic [CH-1:0] pos_out;

  dot_line_latch dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot), .shift_fwd(shift_fwd),
    .inv_lo(inv_lo), .inv_hi(inv_hi), .din(din), .ld(ld), .pol(pol),
    .code_out(code_out), .pos_out(pos_out)
  );

  int checks = 0, failures = 0;
  bit done = 0, started = 0;
  string cur_req = "R1";

  // behavioural reference
  int ref_in[CH];
  int ref_out[CH];
  bit ref_pol;
  bit h1, h2, h3, p1, p2;

  always @(posedge clk) begin : model
    int g, v;
    if (rst) begin
      for (int i = 0; i < CH; i++) begin ref_in[i] = 0; ref_out[i] = 0; end
      ref_pol = 0; h1 = 0; h2 = 0; h3 = 0; p1 = 0; p2 = 0;
    end else begin
      if (h2 && !h3) begin
        for (int i = 0; i < CH; i++) ref_out[i] = ref_in[i];
        ref_pol = p2;
      end
      if (wr_en && int'(wr_slot) < GR) begin
        g = shift_fwd ? int'(wr_slot) : GR - 1 - int'(wr_slot);
        for (int j = 0; j < SPC; j++) begin
          v = int'(din[j*6 +: 6]);
          if ((j < 3) ? inv_lo : inv_hi) v = 63 - v;
          ref_in[g*SPC + j] = v;
        end
      end
      h3 = h2; h2 = h1; h1 = ld;
      p2 = p1; p1 = pol;
    end
    started = 1;
  end

  function automatic bit exp_pos(int i, bit pq);
    int n;
    n = i + 1;
    return pq ? (n % 2 == 0) : (n % 2 == 1);
  endfunction

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      int bad_c, bad_p;
      bad_c = -1; bad_p = -1;
      for (int i = 0; i < CH; i++) begin
        if (bad_c < 0 && int'(code_out[i*BW +: BW]) != ref_out[i]) bad_c = i;
        if (bad_p < 0 && pos_out[i] != exp_pos(i, ref_pol)) bad_p = i;
      end
      checks += 2;
      if (bad_c >= 0) begin
        failures++;
        $display("FAIL %s code ch=%0d actual=%h expected=%h", cur_req, bad_c + 1,
                 code_out[bad_c*BW +: BW], ref_out[bad_c]);
      end
      if (bad_p >= 0) begin
        failures++;
        $display("FAIL %s pos ch=%0d actual=%0d expected=%0d", cur_req, bad_p + 1,
                 pos_out[bad_p], exp_pos(bad_p, ref_pol));
      end
    end
  end

  task automatic chk(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  function automatic int code_at(int n);
    return int'(code_out[(n-1)*BW +: BW]);
  endfunction

  function automatic int smp(int k, int j, int seed);
    return (k*7 + j*11 + seed*5 + 3) % 64;
  endfunction

  function automatic logic [35:0] row(int k, int seed);
    logic [35:0] w;
    for (int j = 0; j < SPC; j++) w[j*6 +: 6] = 6'(smp(k, j, seed));
    return w;
  endfunction

  task automatic put(bit en, int slot, logic [35:0] d, bit il, bit ih, bit l, bit p);
    @(negedge clk);
    wr_en = en; wr_slot = 7'(slot); din = d; inv_lo = il; inv_hi = ih; ld = l; pol = p;
  endtask

  task automatic idle(int n, bit p);
    for (int i = 0; i < n; i++) put(0, 0, '0, 0, 0, 0, p);
  endtask

  task automatic pulse_ld(bit p);
    put(0, 0, '0, 0, 0, 1, p);
    idle(5, p);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2, 0);
    // R1 reset state
    chk("R1 ch1 code", code_at(1), 0);
    chk("R1 ch420 code", code_at(420), 0);
    chk("R1 pos ch1", int'(pos_out[0]), 1);
    chk("R1 pos ch2", int'(pos_out[1]), 0);

    // R2/R4 forward direction, full line
    cur_req = "R4";
    shift_fwd = 1;
    for (int k = 0; k < GR; k++) put(1, k, row(k, 1), 0, 0, 0, 0);
    pulse_ld(0);
    chk("R2 ch1 = slot0 sample0", code_at(1), smp(0, 0, 1));
    chk("R2 ch2 = slot0 sample1", code_at(2), smp(0, 1, 1));
    chk("R4 fwd ch420 = slot69 sample5", code_at(420), smp(69, 5, 1));

    // R3 inversion with reverse direction, R8 pol=1
    cur_req = "R3";
    shift_fwd = 0;
    for (int k = 0; k < GR; k++) begin
      if (k < 3) put(1, k, {6'h15, 6'h07, 6'h00, 6'h15, 6'h07, 6'h00}, (k != 1), (k != 0), 0, 1);
      else put(1, k, row(k, 2), k[0], k[1], 0, 1);
    end
    pulse_ld(1);
    chk("R3 inv_lo 00->3F ch415", code_at(415), 'h3F);
    chk("R3 inv_lo 07->38 ch416", code_at(416), 'h38);
    chk("R3 inv_lo 15->2A ch417", code_at(417), 'h2A);
    chk("R3 hi kept ch418", code_at(418), 'h00);
    chk("R3 inv_hi only ch409 kept", code_at(409), 'h00);
    chk("R3 inv_hi only ch414 15->2A", code_at(414), 'h2A);
    chk("R4 rev ch1 = slot69 sample0", code_at(1), 63 - smp(69, 0, 2));
    chk("R8 pol1 ch2 positive", int'(pos_out[1]), 1);
    chk("R8 pol1 ch1 negative", int'(pos_out[0]), 0);

    // R7 partial line
    cur_req = "R7";
    shift_fwd = 1;
    for (int k = 3; k < 6; k++) put(1, k, row(k, 3), 0, 0, 0, 0);
    pulse_ld(0);
    chk("R7 new ch19", code_at(19), smp(3, 0, 3));
    chk("R7 old ch1 kept", code_at(1), 63 - smp(69, 0, 2));
    chk("R8 pol0 ch1 positive", int'(pos_out[0]), 1);

    // R10 ignored writes
    cur_req = "R10";
    put(0, 0, row(0, 9), 0, 0, 0, 0);
    put(1, 70, row(0, 9), 0, 0, 0, 0);
    put(1, 127, row(1, 9), 0, 0, 0, 0);
    pulse_ld(0);
    chk("R10 ch1 unchanged", code_at(1), 63 - smp(69, 0, 2));

    // R5 writes without a load stay hidden
    cur_req = "R5";
    for (int k = 0; k < 10; k++) put(1, k, row(k, 4), 0, 0, 0, 0);
    idle(4, 0);
    chk("R5 ch1 still old", code_at(1), 63 - smp(69, 0, 2));

    // R6/R9 strobe held high while writing
    cur_req = "R9";
    for (int k = 0; k < 10; k++) put(1, k, row(k, 5), 0, 0, 1, 1);
    idle(5, 1);
    chk("R6 E1 write included ch7", code_at(7), smp(1, 0, 5));
    chk("R6 E2 write excluded ch13", code_at(13), smp(2, 0, 4));
    chk("R9 no second transfer ch55", code_at(55), smp(9, 0, 4));
    pulse_ld(1);
    chk("R6 next load ch13", code_at(13), smp(2, 0, 5));
    finish_run();
  end
endmodule